// File: doc/BRIEF.md
# Snapshot Position Read Port

This block connects a free-running position counter to a narrow host data bus. A holding register copies the counter on every rising clock edge. The host reads the position one byte at a time, using a byte-select pin and an active-low output enable.

A read of the upper byte freezes the holding register. The lower byte, read later, therefore comes from the same snapshot as the upper byte. Both bus control pins are sampled on the falling clock edge. The freeze takes effect at the following rising edge. The freeze stays on through bus idle gaps and repeated upper-byte reads. It is lifted once output enable is seen high after a lower-byte access. A reset also lifts it.

The data pins drive the bus only while output enable is low. At all other times they are high impedance.

Top module: `pos_read_latch`

## Requirements
- R1: Reset clears the holding register to zero and lifts any freeze. With output enable high the bus is not driven.
- R2: The data pins drive the bus, and `bus_drive` is 1, exactly while `bus_oe_n` is 0. This is combinational, with no clock delay.
- R3: `byte_sel` = 0 places bits [15:8] of the holding register on the bus. `byte_sel` = 1 places bits [7:0].
- R4: While no freeze is active, the holding register loads `count_i` on every rising clock edge.
- R5: `bus_oe_n` and `byte_sel` are sampled on the falling edge. An upper-byte access sampled while unfrozen starts a freeze from the next rising edge. The snapshot is the count captured at the rising edge that precedes that falling edge.
- R6: Once a freeze has started, it holds through cycles with output enable high and through further upper-byte accesses, until a lower-byte access is sampled.
- R7: After a lower-byte access, the first falling edge that samples `bus_oe_n` high ends the freeze. The next rising edge loads `count_i` again.
- R8: A lower-byte access sampled while unfrozen does not start a freeze, and the register keeps following the counter.
- R9: If the counter steps from 0000h to FFFFh and an upper-byte read then starts, both bytes read back as FFh.
- R10: A reset applied during a freeze lifts it. Normal loading resumes after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on the rising edge, control pins are sampled on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Position value from the external counter |
| bus_oe_n | input | 1 | Active-low output enable for the data pins |
| byte_sel | input | 1 | Byte select: 0 = upper byte, 1 = lower byte |
| bus_dq | output | 8 | Tri-state data pins |
| bus_drive | output | 1 | High while the data pins drive the bus |

## Verification
The assertions assume that `bus_oe_n` and `byte_sel` change only in the first half of the clock period. The falling-edge sample then sees a settled value, and the state machine and holding register see a consistent pair at each rising edge. The bench applies every control and count change two time units after a rising edge and samples eight units after it. All stimulus therefore lies between a rising edge and the following falling edge. The counter input is treated as arbitrary data, so the freeze checks hold for any count sequence the bench chooses.

// File: rtl/pos_latch_pkg.sv
package pos_latch_pkg;

  typedef enum logic [1:0] {
    RD_FREE    = 2'd0,
    RD_HOLD_HI = 2'd1,
    RD_HOLD_LO = 2'd2
  } rd_state_e;

  // Whether the holding register must keep its value at the coming rising edge.
  function automatic logic freeze_for(rd_state_e st, logic oe_act, logic sel_lo);
    logic f;
    case (st)
      RD_HOLD_HI: f = 1'b1;
      RD_HOLD_LO: f = oe_act;
      default:    f = oe_act & ~sel_lo;
    endcase
    return f;
  endfunction

  // Read sequence state after a rising edge, given the falling-edge samples.
  function automatic rd_state_e step_state(rd_state_e st, logic oe_act, logic sel_lo);
    rd_state_e n;
    n = st;
    case (st)
      RD_FREE:    if (oe_act && !sel_lo) n = RD_HOLD_HI;
      RD_HOLD_HI: if (oe_act && sel_lo)  n = RD_HOLD_LO;
      RD_HOLD_LO: if (!oe_act)           n = RD_FREE;
      default:    n = RD_FREE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pl_ctl_sample.sv
module pl_ctl_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n_i,
  input  logic sel_i,
  output logic oe_act_s,
  output logic sel_s
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_act_s <= 1'b0;
      sel_s    <= 1'b0;
    end else begin
      oe_act_s <= ~oe_n_i;
      sel_s    <= sel_i;
    end
  end

endmodule

// File: rtl/pl_inhibit_fsm.sv
module pl_inhibit_fsm
  import pos_latch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      oe_act_s,
  input  logic      sel_s,
  output rd_state_e state_q,
  output logic      freeze
);

  rd_state_e state_d;

  always_comb begin
    state_d = step_state(state_q, oe_act_s, sel_s);
    freeze  = freeze_for(state_q, oe_act_s, sel_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RD_FREE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pl_snap_reg.sv
module pl_snap_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= '0;
    else if (!freeze) q_o <= d_i;
  end

endmodule

// File: rtl/pl_byte_mux.sv
module pl_byte_mux #(
  parameter int BUS_W = 8,
  parameter int NBYTE = 2
) (
  input  logic [BUS_W*NBYTE-1:0] word_i,
  input  logic                   sel_lo,
  output logic [BUS_W-1:0]       byte_o
);

  localparam int TOP = NBYTE - 1;

  logic [BUS_W-1:0] slice [NBYTE];

  for (genvar g = 0; g < NBYTE; g++) begin : g_slice
    assign slice[g] = word_i[g*BUS_W +: BUS_W];
  end

  // sel_lo = 1 picks the least significant byte, 0 the most significant one.
  assign byte_o = sel_lo ? slice[0] : slice[TOP];

endmodule

// File: rtl/pos_read_latch.sv
module pos_read_latch
  import pos_latch_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*BUS_W-1:0] count_i,
  input  logic               bus_oe_n,
  input  logic               byte_sel,
  output logic [BUS_W-1:0]   bus_dq,
  output logic               bus_drive
);

  localparam int CNT_W = 2 * BUS_W;

  logic             oe_act_s;
  logic             sel_s;
  rd_state_e        rd_state;
  logic             hold_w;
  logic [CNT_W-1:0] snap_q;
  logic [BUS_W-1:0] mux_q;

  pl_ctl_sample u_sample (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n_i   (bus_oe_n),
    .sel_i    (byte_sel),
    .oe_act_s (oe_act_s),
    .sel_s    (sel_s)
  );

  pl_inhibit_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_act_s (oe_act_s),
    .sel_s    (sel_s),
    .state_q  (rd_state),
    .freeze   (hold_w)
  );

  pl_snap_reg #(.W(CNT_W)) u_snap (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (hold_w),
    .d_i    (count_i),
    .q_o    (snap_q)
  );

  pl_byte_mux #(.BUS_W(BUS_W), .NBYTE(2)) u_mux (
    .word_i (snap_q),
    .sel_lo (byte_sel),
    .byte_o (mux_q)
  );

  assign bus_drive = ~bus_oe_n;
  assign bus_dq    = bus_drive ? mux_q : {BUS_W{1'bz}};

endmodule

// File: rtl/pos_read_latch_chk.sv
module pos_read_latch_chk
  import pos_latch_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*BUS_W-1:0] count_i,
  input logic               oe_act_s,
  input logic               sel_s,
  input rd_state_e          state,
  input logic               hold,
  input logic [2*BUS_W-1:0] snap
);

  assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> snap == $past(count_i));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(snap));

  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_FREE && oe_act_s && !sel_s) |=> state == RD_HOLD_HI);

  assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_HOLD_HI && !(oe_act_s && sel_s)) |=> state == RD_HOLD_HI);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_HOLD_LO && !oe_act_s) |=> state == RD_FREE);

  assert_low_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_FREE && oe_act_s && sel_s) |=> (state == RD_FREE && snap == $past(count_i)));

endmodule

bind pos_read_latch pos_read_latch_chk #(.BUS_W(BUS_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .count_i (count_i),
  .oe_act_s(oe_act_s),
  .sel_s   (sel_s),
  .state   (rd_state),
  .hold    (hold_w),
  .snap    (snap_q)
);

// File: tb/tb_pos_read_latch.sv
module tb_pos_read_latch;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic        oe_n;
    logic        sel;
    logic [15:0] cnt;
    logic        drv;
    logic [7:0]  dat;
  } vec_t;

  // Applied 2 units after rising edge k, checked 8 units after it.
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 16'h1234, 1'b0, 8'h00},
    '{1'b1, 1'b0, 16'h1234, 1'b0, 8'h00},
    '{1'b0, 1'b0, 16'h5678, 1'b1, 8'h12},
    '{1'b0, 1'b0, 16'h9ABC, 1'b1, 8'h12},
    '{1'b1, 1'b0, 16'h9ABC, 1'b0, 8'h00},
    '{1'b0, 1'b1, 16'hDEF0, 1'b1, 8'h34},
    '{1'b0, 1'b1, 16'hDEF0, 1'b1, 8'h34},
    '{1'b1, 1'b1, 16'hDEF0, 1'b0, 8'h00},
    '{1'b0, 1'b1, 16'h1111, 1'b1, 8'hF0},
    '{1'b0, 1'b1, 16'h2222, 1'b1, 8'h11},
    '{1'b1, 1'b0, 16'h0000, 1'b0, 8'h00},
    '{1'b1, 1'b0, 16'hFFFF, 1'b0, 8'h00},
    '{1'b0, 1'b0, 16'hFFFE, 1'b1, 8'hFF},
    '{1'b0, 1'b1, 16'hFFFD, 1'b1, 8'hFF},
    '{1'b1, 1'b1, 16'hFFFC, 1'b0, 8'h00},
    '{1'b0, 1'b1, 16'h0100, 1'b1, 8'hFC}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] count_i = '0;
  logic        bus_oe_n = 1'b1;
  logic        byte_sel = 1'b0;
  wire  [7:0]  bus_dq;
  logic        bus_drive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pos_read_latch dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_i  (count_i),
    .bus_oe_n (bus_oe_n),
    .byte_sel (byte_sel),
    .bus_dq   (bus_dq),
    .bus_drive(bus_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string vec_tag(int k);
    case (k)
      2:       return "R3";
      3:       return "R5";
      5, 6:    return "R6";
      8, 15:   return "R7";
      9:       return "R8";
      12, 13:  return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic at_drive();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: during reset the bus is idle and the holding register is zero.
    #3;
    chk("R1", {15'd0, bus_drive}, 16'd0);
    count_i  = 16'hABCD;
    bus_oe_n = 1'b0;
    byte_sel = 1'b1;
    @(posedge clk); #8;
    chk("R1", {8'd0, bus_dq}, 16'h0000);
    chk("R2", {15'd0, bus_drive}, 16'd1);
    bus_oe_n = 1'b1;
    count_i  = 16'h0000;
    @(posedge clk); #2;
    rst_n = 1'b1;

    // Vector table walk.
    for (int k = 0; k < NVEC; k++) begin
      at_drive();
      bus_oe_n = VEC[k].oe_n;
      byte_sel = VEC[k].sel;
      count_i  = VEC[k].cnt;
      #6;
      chk(vec_tag(k), {15'd0, bus_drive}, {15'd0, VEC[k].drv});
      if (VEC[k].drv) chk(vec_tag(k), {8'd0, bus_dq}, {8'd0, VEC[k].dat});
    end

    // R4: lower-byte reads over consecutive cycles track the counter.
    at_drive();
    bus_oe_n = 1'b1;
    count_i  = 16'h0A05;
    for (int k = 0; k < 4; k++) begin
      at_drive();
      bus_oe_n = 1'b0;
      byte_sel = 1'b1;
      count_i  = 16'h0A06 + 16'(k);
      #6;
      chk("R4", {8'd0, bus_dq}, {8'd0, 8'h05 + 8'(k)});
    end

    // R10: reset during a freeze lifts it.
    at_drive();
    bus_oe_n = 1'b1;
    count_i  = 16'h4321;
    at_drive();
    bus_oe_n = 1'b0;
    byte_sel = 1'b0;
    count_i  = 16'h8765;
    #6;
    chk("R5", {8'd0, bus_dq}, 16'h0043);
    at_drive();
    bus_oe_n = 1'b1;
    at_drive();
    rst_n = 1'b0;
    at_drive();
    rst_n = 1'b1;
    at_drive();
    at_drive();
    bus_oe_n = 1'b0;
    byte_sel = 1'b1;
    #6;
    chk("R10", {8'd0, bus_dq}, 16'h0065);
    at_drive();
    bus_oe_n = 1'b1;
    #1;
    chk("R2", {15'd0, bus_drive}, 16'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule